// File: doc/BRIEF.md
# Reorder buffer with tag broadcast

This block keeps in-flight instructions in program order inside a circular buffer of `DEPTH` slots. A dispatch port allocates the slot at the tail and hands back its index, which is the tag under which the instruction's result will later be delivered. Each slot records the destination register, an instruction class, the fetch address, a branch target and a predicted direction. It also holds two source operands. Each operand is either already known, or waits on the tag of the slot that produces it.

A result bus delivers a tag, a value and an exception flag. In one cycle the block stores that result in the producing slot and hands the value to every waiting operand in the buffer that names the tag. This includes the operands of an instruction being dispatched in that same cycle. Issue logic can read any slot by index, and execute logic can write a result straight into a slot without a broadcast. The oldest slot leaves through the retire port as soon as its result is present. If that result carries an exception, the whole buffer is emptied. A flush input empties it on demand.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, `ret_valid` is 0 and `rd_busy` is 0 for every index.
- R2: An accepted dispatch fills the slot whose index equals `disp_tag`, and `disp_tag` then advances by one, wrapping from `DEPTH-1` to 0 (`DEPTH` is a power of two).
- R3: With `DEPTH` slots occupied, `disp_ready` is 0 and a dispatch request changes neither `disp_tag` nor any slot.
- R4: `ret_valid` is 1 exactly when the slot at the head (`ret_tag`) is occupied and holds its result. It then presents that slot's destination, value and exception flag, and the slot is released on the next edge. Slots retire in dispatch order.
- R5: A broadcast whose tag names an occupied slot marks that slot's result present and stores the value and exception flag there. A broadcast to a free slot changes nothing.
- R6: In the cycle of a broadcast, every occupied slot whose operand is still waiting on the broadcast tag captures the value and becomes ready. Operands that are already ready keep their value.
- R7: When a broadcast coincides with a dispatch whose operand waits on the broadcast tag, the new slot records that operand as ready with the broadcast value.
- R8: The read port returns, combinationally for slot `rd_idx`, its occupancy, result state, destination, class, address, target, prediction, and both operands with their tags.
- R9: A direct write to an occupied slot marks its result present with the written value and flag. If a broadcast targets the same slot in the same cycle, the broadcast's value is kept.
- R10: When the head retires with its exception flag set, every slot is released on the next edge, and the tail and head return to 0. A dispatch in that cycle is dropped.
- R11: `flush_req` empties the buffer on the next edge in the same way, overriding any dispatch, broadcast or direct write in that cycle.
- R12: Dispatch, broadcast, direct write and retire may all happen in one cycle, each with the effect it would have alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | REG_W | Destination register of the new instruction |
| disp_type | input | TYPE_W | Instruction class |
| disp_pc | input | ADDR_W | Fetch address |
| disp_target | input | ADDR_W | Branch target |
| disp_pred | input | 1 | Predicted branch direction |
| disp_s1_ready | input | 1 | First operand value already known |
| disp_s1_val | input | DATA_W | First operand value |
| disp_s1_tag | input | IDX_W | Producer tag of the first operand |
| disp_s2_ready | input | 1 | Second operand value already known |
| disp_s2_val | input | DATA_W | Second operand value |
| disp_s2_tag | input | IDX_W | Producer tag of the second operand |
| disp_ready | output | 1 | A free slot exists |
| disp_tag | output | IDX_W | Index the next dispatch will occupy |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | IDX_W | Tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| bc_exc | input | 1 | Broadcast result raised an exception |
| wr_valid | input | 1 | Direct result write |
| wr_idx | input | IDX_W | Slot for the direct write |
| wr_value | input | DATA_W | Directly written value |
| wr_exc | input | 1 | Directly written exception flag |
| rd_idx | input | IDX_W | Slot selected for reading |
| rd_busy | output | 1 | Selected slot occupied |
| rd_done | output | 1 | Selected slot holds its result |
| rd_exc | output | 1 | Exception flag of the selected slot |
| rd_value | output | DATA_W | Result value of the selected slot |
| rd_dest | output | REG_W | Destination of the selected slot |
| rd_type | output | TYPE_W | Class of the selected slot |
| rd_pc | output | ADDR_W | Address of the selected slot |
| rd_target | output | ADDR_W | Branch target of the selected slot |
| rd_pred | output | 1 | Prediction of the selected slot |
| rd_s1_ok | output | 1 | First operand ready |
| rd_s1_val | output | DATA_W | First operand value |
| rd_s1_tag | output | IDX_W | First operand producer tag |
| rd_s2_ok | output | 1 | Second operand ready |
| rd_s2_val | output | DATA_W | Second operand value |
| rd_s2_tag | output | IDX_W | Second operand producer tag |
| flush_req | input | 1 | Empty the whole buffer |
| ret_valid | output | 1 | Head slot retires this cycle |
| ret_tag | output | IDX_W | Index of the head slot |
| ret_dest | output | REG_W | Destination of the retiring instruction |
| ret_value | output | DATA_W | Result of the retiring instruction |
| ret_exc | output | 1 | Retiring instruction raised an exception |

## Verification
Every input takes effect at the next rising edge, through one register stage inside a slot or the pointer logic. The retire, read and dispatch-status outputs are combinational views of that stored state. So a dispatch, broadcast, direct write or flush is visible on the outputs exactly one cycle after it is driven, and a retire that the outputs show in a cycle has released its slot one cycle later. The bench drives inputs just after a falling edge and compares the outputs 1 ns later against a behavioural model that holds the state reached after the previous edge. It then advances the model by one cycle using the inputs it has just driven. Outputs are therefore checked in every cycle at the single point where their value is due.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Which source updates a slot's result in a given cycle.
    typedef enum logic [1:0] {
        RES_HOLD   = 2'd0,
        RES_BCAST  = 2'd1,
        RES_DIRECT = 2'd2
    } res_src_e;

    // Number of source operands tracked per slot.
    localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PTR_W = IDX_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] hd;
        logic [PTR_W-1:0] tl;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (push_i) ptr_d.tl = ptr_q.tl + 1'b1;
        if (pop_i)  ptr_d.hd = ptr_q.hd + 1'b1;
        if (flush_i) ptr_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign head_o  = ptr_q.hd[IDX_W-1:0];
    assign tail_o  = ptr_q.tl[IDX_W-1:0];
    assign empty_o = (ptr_q.hd == ptr_q.tl);
    assign full_o  = (ptr_q.hd[IDX_W-1:0] == ptr_q.tl[IDX_W-1:0]) &&
                     (ptr_q.hd[IDX_W] != ptr_q.tl[IDX_W]);

endmodule

// File: rtl/rob_slot.sv
module rob_slot
    import rob_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 5,
    parameter int TYPE_W = 3,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int SLOT   = 0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush_i,
    input  logic                            alloc_i,
    input  logic                            release_i,
    input  logic [REG_W-1:0]                a_dest_i,
    input  logic [TYPE_W-1:0]               a_type_i,
    input  logic [ADDR_W-1:0]               a_pc_i,
    input  logic [ADDR_W-1:0]               a_target_i,
    input  logic                            a_pred_i,
    input  logic [NUM_SRC-1:0]              a_src_ok_i,
    input  logic [NUM_SRC-1:0][DATA_W-1:0]  a_src_val_i,
    input  logic [NUM_SRC-1:0][IDX_W-1:0]   a_src_tag_i,
    input  logic                            bc_valid_i,
    input  logic [IDX_W-1:0]                bc_tag_i,
    input  logic [DATA_W-1:0]               bc_value_i,
    input  logic                            bc_exc_i,
    input  logic                            wr_valid_i,
    input  logic [IDX_W-1:0]                wr_idx_i,
    input  logic [DATA_W-1:0]               wr_value_i,
    input  logic                            wr_exc_i,
    output logic                            occ_o,
    output logic                            done_o,
    output logic                            exc_o,
    output logic [DATA_W-1:0]               value_o,
    output logic [REG_W-1:0]                dest_o,
    output logic [TYPE_W-1:0]               type_o,
    output logic [ADDR_W-1:0]               pc_o,
    output logic [ADDR_W-1:0]               target_o,
    output logic                            pred_o,
    output logic [NUM_SRC-1:0]              src_ok_o,
    output logic [NUM_SRC-1:0][DATA_W-1:0]  src_val_o,
    output logic [NUM_SRC-1:0][IDX_W-1:0]   src_tag_o
);
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT);

    typedef struct packed {
        logic                           occ;
        logic                           done;
        logic                           exc;
        logic [DATA_W-1:0]              value;
        logic [REG_W-1:0]               dest;
        logic [TYPE_W-1:0]              itype;
        logic [ADDR_W-1:0]              pc;
        logic [ADDR_W-1:0]              target;
        logic                           pred;
        logic [NUM_SRC-1:0]             src_ok;
        logic [NUM_SRC-1:0][DATA_W-1:0] src_val;
        logic [NUM_SRC-1:0][IDX_W-1:0]  src_tag;
    } slot_t;

    slot_t    slot_d, slot_q;
    res_src_e res_sel;

    always_comb begin
        slot_d  = slot_q;
        res_sel = RES_HOLD;
        if (slot_q.occ) begin
            // Result capture: broadcast takes precedence over direct write.
            if (bc_valid_i && (bc_tag_i == MY_IDX))
                res_sel = RES_BCAST;
            else if (wr_valid_i && (wr_idx_i == MY_IDX))
                res_sel = RES_DIRECT;
            case (res_sel)
                RES_BCAST: begin
                    slot_d.done  = 1'b1;
                    slot_d.value = bc_value_i;
                    slot_d.exc   = bc_exc_i;
                end
                RES_DIRECT: begin
                    slot_d.done  = 1'b1;
                    slot_d.value = wr_value_i;
                    slot_d.exc   = wr_exc_i;
                end
                default: ;
            endcase
            // Operand wakeup on matching broadcast tag.
            for (int s = 0; s < NUM_SRC; s++) begin
                if (!slot_q.src_ok[s] && bc_valid_i && (bc_tag_i == slot_q.src_tag[s])) begin
                    slot_d.src_ok[s]  = 1'b1;
                    slot_d.src_val[s] = bc_value_i;
                end
            end
        end
        if (release_i) slot_d.occ = 1'b0;
        if (alloc_i) begin
            slot_d.occ     = 1'b1;
            slot_d.done    = 1'b0;
            slot_d.exc     = 1'b0;
            slot_d.value   = '0;
            slot_d.dest    = a_dest_i;
            slot_d.itype   = a_type_i;
            slot_d.pc      = a_pc_i;
            slot_d.target  = a_target_i;
            slot_d.pred    = a_pred_i;
            slot_d.src_ok  = a_src_ok_i;
            slot_d.src_val = a_src_val_i;
            slot_d.src_tag = a_src_tag_i;
        end
        if (flush_i) slot_d.occ = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign occ_o     = slot_q.occ;
    assign done_o    = slot_q.done;
    assign exc_o     = slot_q.exc;
    assign value_o   = slot_q.value;
    assign dest_o    = slot_q.dest;
    assign type_o    = slot_q.itype;
    assign pc_o      = slot_q.pc;
    assign target_o  = slot_q.target;
    assign pred_o    = slot_q.pred;
    assign src_ok_o  = slot_q.src_ok;
    assign src_val_o = slot_q.src_val;
    assign src_tag_o = slot_q.src_tag;

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int REG_W  = 5,
    parameter int TYPE_W = 3,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [REG_W-1:0]  disp_dest,
    input  logic [TYPE_W-1:0] disp_type,
    input  logic [ADDR_W-1:0] disp_pc,
    input  logic [ADDR_W-1:0] disp_target,
    input  logic              disp_pred,
    input  logic              disp_s1_ready,
    input  logic [DATA_W-1:0] disp_s1_val,
    input  logic [IDX_W-1:0]  disp_s1_tag,
    input  logic              disp_s2_ready,
    input  logic [DATA_W-1:0] disp_s2_val,
    input  logic [IDX_W-1:0]  disp_s2_tag,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_tag,
    input  logic              bc_valid,
    input  logic [IDX_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              bc_exc,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_value,
    input  logic              wr_exc,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_busy,
    output logic              rd_done,
    output logic              rd_exc,
    output logic [DATA_W-1:0] rd_value,
    output logic [REG_W-1:0]  rd_dest,
    output logic [TYPE_W-1:0] rd_type,
    output logic [ADDR_W-1:0] rd_pc,
    output logic [ADDR_W-1:0] rd_target,
    output logic              rd_pred,
    output logic              rd_s1_ok,
    output logic [DATA_W-1:0] rd_s1_val,
    output logic [IDX_W-1:0]  rd_s1_tag,
    output logic              rd_s2_ok,
    output logic [DATA_W-1:0] rd_s2_val,
    output logic [IDX_W-1:0]  rd_s2_tag,
    input  logic              flush_req,
    output logic              ret_valid,
    output logic [IDX_W-1:0]  ret_tag,
    output logic [REG_W-1:0]  ret_dest,
    output logic [DATA_W-1:0] ret_value,
    output logic              ret_exc
);
    typedef struct packed {
        logic                           push;
        logic                           pop;
        logic                           flush;
        logic [NUM_SRC-1:0]             src_ok;
        logic [NUM_SRC-1:0][DATA_W-1:0] src_val;
        logic [NUM_SRC-1:0][IDX_W-1:0]  src_tag;
    } ctl_t;

    ctl_t ctl_d;

    logic [IDX_W-1:0] head_idx, tail_idx;
    logic             full, empty;

    // Per-slot views
    logic [DEPTH-1:0]               occ, done, exc, pred;
    logic [DATA_W-1:0]              value  [DEPTH];
    logic [REG_W-1:0]               dest   [DEPTH];
    logic [TYPE_W-1:0]              itype  [DEPTH];
    logic [ADDR_W-1:0]              pc     [DEPTH];
    logic [ADDR_W-1:0]              target [DEPTH];
    logic [NUM_SRC-1:0]             s_ok   [DEPTH];
    logic [NUM_SRC-1:0][DATA_W-1:0] s_val  [DEPTH];
    logic [NUM_SRC-1:0][IDX_W-1:0]  s_tag  [DEPTH];

    logic             head_ready;
    logic [NUM_SRC-1:0]             in_ok;
    logic [NUM_SRC-1:0][DATA_W-1:0] in_val;
    logic [NUM_SRC-1:0][IDX_W-1:0]  in_tag;

    assign in_ok  = {disp_s2_ready, disp_s1_ready};
    assign in_val = {disp_s2_val, disp_s1_val};
    assign in_tag = {disp_s2_tag, disp_s1_tag};

    assign head_ready = !empty && occ[head_idx] && done[head_idx];

    always_comb begin
        ctl_d         = '0;
        ctl_d.pop     = head_ready;
        ctl_d.flush   = flush_req || (head_ready && exc[head_idx]);
        ctl_d.push    = disp_valid && !full && !ctl_d.flush;
        ctl_d.src_tag = in_tag;
        // Operands of the incoming instruction see this cycle's broadcast.
        for (int s = 0; s < NUM_SRC; s++) begin
            ctl_d.src_ok[s]  = in_ok[s];
            ctl_d.src_val[s] = in_val[s];
            if (!in_ok[s] && bc_valid && (bc_tag == in_tag[s])) begin
                ctl_d.src_ok[s]  = 1'b1;
                ctl_d.src_val[s] = bc_value;
            end
        end
    end

    rob_ptr_ctl #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (ctl_d.push),
        .pop_i   (ctl_d.pop),
        .flush_i (ctl_d.flush),
        .head_o  (head_idx),
        .tail_o  (tail_idx),
        .full_o  (full),
        .empty_o (empty)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rob_slot #(
            .DATA_W (DATA_W),
            .REG_W  (REG_W),
            .TYPE_W (TYPE_W),
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W),
            .SLOT   (g)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (ctl_d.flush),
            .alloc_i     (ctl_d.push && (tail_idx == IDX_W'(g))),
            .release_i   (ctl_d.pop && (head_idx == IDX_W'(g))),
            .a_dest_i    (disp_dest),
            .a_type_i    (disp_type),
            .a_pc_i      (disp_pc),
            .a_target_i  (disp_target),
            .a_pred_i    (disp_pred),
            .a_src_ok_i  (ctl_d.src_ok),
            .a_src_val_i (ctl_d.src_val),
            .a_src_tag_i (ctl_d.src_tag),
            .bc_valid_i  (bc_valid),
            .bc_tag_i    (bc_tag),
            .bc_value_i  (bc_value),
            .bc_exc_i    (bc_exc),
            .wr_valid_i  (wr_valid),
            .wr_idx_i    (wr_idx),
            .wr_value_i  (wr_value),
            .wr_exc_i    (wr_exc),
            .occ_o       (occ[g]),
            .done_o      (done[g]),
            .exc_o       (exc[g]),
            .value_o     (value[g]),
            .dest_o      (dest[g]),
            .type_o      (itype[g]),
            .pc_o        (pc[g]),
            .target_o    (target[g]),
            .pred_o      (pred[g]),
            .src_ok_o    (s_ok[g]),
            .src_val_o   (s_val[g]),
            .src_tag_o   (s_tag[g])
        );
    end

    // Dispatch status
    assign disp_ready = !full;
    assign disp_tag   = tail_idx;

    // Retire view of the head slot
    assign ret_valid = head_ready;
    assign ret_tag   = head_idx;
    assign ret_dest  = dest[head_idx];
    assign ret_value = value[head_idx];
    assign ret_exc   = exc[head_idx];

    // Indexed read port
    assign rd_busy   = occ[rd_idx];
    assign rd_done   = done[rd_idx];
    assign rd_exc    = exc[rd_idx];
    assign rd_value  = value[rd_idx];
    assign rd_dest   = dest[rd_idx];
    assign rd_type   = itype[rd_idx];
    assign rd_pc     = pc[rd_idx];
    assign rd_target = target[rd_idx];
    assign rd_pred   = pred[rd_idx];
    assign rd_s1_ok  = s_ok[rd_idx][0];
    assign rd_s1_val = s_val[rd_idx][0];
    assign rd_s1_tag = s_tag[rd_idx][0];
    assign rd_s2_ok  = s_ok[rd_idx][1];
    assign rd_s2_val = s_val[rd_idx][1];
    assign rd_s2_tag = s_tag[rd_idx][1];

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_tag,
    input logic             flush_req,
    input logic             ret_valid,
    input logic             ret_exc,
    input logic [IDX_W-1:0] ret_tag
);
    AST_EXC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_exc) |=> (disp_ready && (disp_tag == '0) && !ret_valid)); // R10

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (disp_ready && (disp_tag == '0) && (ret_tag == '0) && !ret_valid)); // R11

    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready && !flush_req && !(ret_valid && ret_exc))
        |=> (disp_tag == IDX_W'($past(disp_tag) + 1'b1))); // R2

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready && !flush_req && !(ret_valid && ret_exc)) |=> $stable(disp_tag)); // R3

    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_exc && !flush_req)
        |=> (ret_tag == IDX_W'($past(ret_tag) + 1'b1))); // R4

endmodule

bind rob_core rob_core_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_tag   (disp_tag),
    .flush_req  (flush_req),
    .ret_valid  (ret_valid),
    .ret_exc    (ret_exc),
    .ret_tag    (ret_tag)
);

// File: tb/rob_core_test.sv
`timescale 1ns/1ps
module rob_core_test;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;
    localparam int REG_W  = 5;
    localparam int TYPE_W = 3;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              disp_valid, disp_pred, disp_s1_ready, disp_s2_ready;
    logic [REG_W-1:0]  disp_dest;
    logic [TYPE_W-1:0] disp_type;
    logic [ADDR_W-1:0] disp_pc, disp_target;
    logic [DATA_W-1:0] disp_s1_val, disp_s2_val;
    logic [IDX_W-1:0]  disp_s1_tag, disp_s2_tag;
    logic              disp_ready;
    logic [IDX_W-1:0]  disp_tag;
    logic              bc_valid, bc_exc, wr_valid, wr_exc, flush_req;
    logic [IDX_W-1:0]  bc_tag, wr_idx, rd_idx;
    logic [DATA_W-1:0] bc_value, wr_value;
    logic              rd_busy, rd_done, rd_exc, rd_pred, rd_s1_ok, rd_s2_ok;
    logic [DATA_W-1:0] rd_value, rd_s1_val, rd_s2_val;
    logic [REG_W-1:0]  rd_dest;
    logic [TYPE_W-1:0] rd_type;
    logic [ADDR_W-1:0] rd_pc, rd_target;
    logic [IDX_W-1:0]  rd_s1_tag, rd_s2_tag;
    logic              ret_valid, ret_exc;
    logic [IDX_W-1:0]  ret_tag;
    logic [REG_W-1:0]  ret_dest;
    logic [DATA_W-1:0] ret_value;

    rob_core #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_type(disp_type),
        .disp_pc(disp_pc), .disp_target(disp_target), .disp_pred(disp_pred),
        .disp_s1_ready(disp_s1_ready), .disp_s1_val(disp_s1_val), .disp_s1_tag(disp_s1_tag),
        .disp_s2_ready(disp_s2_ready), .disp_s2_val(disp_s2_val), .disp_s2_tag(disp_s2_tag),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value), .bc_exc(bc_exc),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_value(wr_value), .wr_exc(wr_exc),
        .rd_idx(rd_idx), .rd_busy(rd_busy), .rd_done(rd_done), .rd_exc(rd_exc),
        .rd_value(rd_value), .rd_dest(rd_dest), .rd_type(rd_type), .rd_pc(rd_pc),
        .rd_target(rd_target), .rd_pred(rd_pred),
        .rd_s1_ok(rd_s1_ok), .rd_s1_val(rd_s1_val), .rd_s1_tag(rd_s1_tag),
        .rd_s2_ok(rd_s2_ok), .rd_s2_val(rd_s2_val), .rd_s2_tag(rd_s2_tag),
        .flush_req(flush_req),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dest(ret_dest),
        .ret_value(ret_value), .ret_exc(ret_exc)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Behavioural reference state
    bit m_occ [DEPTH], m_done [DEPTH], m_exc [DEPTH], m_pred [DEPTH];
    bit m_s1ok [DEPTH], m_s2ok [DEPTH];
    int m_val [DEPTH], m_dest [DEPTH], m_type [DEPTH], m_pc [DEPTH], m_tgt [DEPTH];
    int m_s1v [DEPTH], m_s1t [DEPTH], m_s2v [DEPTH], m_s2t [DEPTH];
    int m_head = 0, m_tail = 0, m_cnt = 0;

    task automatic chk_eq(input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic compare(input string ph);
        bit rv;
        int i;
        rv = (m_cnt > 0) && m_done[m_head];
        chk_eq({ph, " R3 disp_ready"}, longint'(disp_ready), longint'(m_cnt < DEPTH));
        chk_eq({ph, " R2 disp_tag"}, longint'(disp_tag), longint'(m_tail));
        chk_eq({ph, " R4 ret_valid"}, longint'(ret_valid), longint'(rv));
        chk_eq({ph, " R4 ret_tag"}, longint'(ret_tag), longint'(m_head));
        if (rv) begin
            chk_eq({ph, " R4 ret_dest"}, longint'(ret_dest), longint'(m_dest[m_head]));
            chk_eq({ph, " R4 ret_value"}, longint'(ret_value), longint'(m_val[m_head]));
            chk_eq({ph, " R10 ret_exc"}, longint'(ret_exc), longint'(m_exc[m_head]));
        end
        i = int'(rd_idx);
        chk_eq({ph, " R8 rd_busy"}, longint'(rd_busy), longint'(m_occ[i]));
        if (m_occ[i]) begin
            chk_eq({ph, " R8 rd_dest"}, longint'(rd_dest), longint'(m_dest[i]));
            chk_eq({ph, " R8 rd_type"}, longint'(rd_type), longint'(m_type[i]));
            chk_eq({ph, " R8 rd_pc"}, longint'(rd_pc), longint'(m_pc[i]));
            chk_eq({ph, " R8 rd_target"}, longint'(rd_target), longint'(m_tgt[i]));
            chk_eq({ph, " R8 rd_pred"}, longint'(rd_pred), longint'(m_pred[i]));
            chk_eq({ph, " R8 rd_s1_tag"}, longint'(rd_s1_tag), longint'(m_s1t[i]));
            chk_eq({ph, " R8 rd_s2_tag"}, longint'(rd_s2_tag), longint'(m_s2t[i]));
            chk_eq({ph, " R5 rd_done"}, longint'(rd_done), longint'(m_done[i]));
            if (m_done[i]) begin
                chk_eq({ph, " R5 rd_value"}, longint'(rd_value), longint'(m_val[i]));
                chk_eq({ph, " R5 rd_exc"}, longint'(rd_exc), longint'(m_exc[i]));
            end
            chk_eq({ph, " R6 rd_s1_ok"}, longint'(rd_s1_ok), longint'(m_s1ok[i]));
            if (m_s1ok[i]) chk_eq({ph, " R6 rd_s1_val"}, longint'(rd_s1_val), longint'(m_s1v[i]));
            chk_eq({ph, " R6 rd_s2_ok"}, longint'(rd_s2_ok), longint'(m_s2ok[i]));
            if (m_s2ok[i]) chk_eq({ph, " R6 rd_s2_val"}, longint'(rd_s2_val), longint'(m_s2v[i]));
        end
    endtask

    // Advance the reference by one clock using the inputs currently driven.
    task automatic model_step();
        bit rv, fl, take;
        int bt, t;
        rv   = (m_cnt > 0) && m_done[m_head];
        fl   = flush_req || (rv && m_exc[m_head]);
        take = disp_valid && (m_cnt < DEPTH);
        bt   = int'(bc_tag);
        for (int i = 0; i < DEPTH; i++) begin
            if (m_occ[i]) begin
                if (bc_valid && bt == i) begin
                    m_done[i] = 1; m_val[i] = int'(bc_value); m_exc[i] = bc_exc;
                end else if (wr_valid && int'(wr_idx) == i) begin
                    m_done[i] = 1; m_val[i] = int'(wr_value); m_exc[i] = wr_exc;
                end
                if (!m_s1ok[i] && bc_valid && m_s1t[i] == bt) begin
                    m_s1ok[i] = 1; m_s1v[i] = int'(bc_value);
                end
                if (!m_s2ok[i] && bc_valid && m_s2t[i] == bt) begin
                    m_s2ok[i] = 1; m_s2v[i] = int'(bc_value);
                end
            end
        end
        if (rv) begin
            m_occ[m_head] = 0;
            m_head = (m_head + 1) % DEPTH;
            m_cnt--;
        end
        if (take) begin
            t = m_tail;
            m_occ[t] = 1; m_done[t] = 0; m_exc[t] = 0;
            m_dest[t] = int'(disp_dest); m_type[t] = int'(disp_type);
            m_pc[t] = int'(disp_pc); m_tgt[t] = int'(disp_target); m_pred[t] = disp_pred;
            m_s1t[t] = int'(disp_s1_tag); m_s2t[t] = int'(disp_s2_tag);
            m_s1ok[t] = disp_s1_ready; m_s1v[t] = int'(disp_s1_val);
            if (!disp_s1_ready && bc_valid && int'(disp_s1_tag) == bt) begin
                m_s1ok[t] = 1; m_s1v[t] = int'(bc_value);
            end
            m_s2ok[t] = disp_s2_ready; m_s2v[t] = int'(disp_s2_val);
            if (!disp_s2_ready && bc_valid && int'(disp_s2_tag) == bt) begin
                m_s2ok[t] = 1; m_s2v[t] = int'(bc_value);
            end
            m_tail = (m_tail + 1) % DEPTH;
            m_cnt++;
        end
        if (fl) begin
            for (int i = 0; i < DEPTH; i++) m_occ[i] = 0;
            m_head = 0; m_tail = 0; m_cnt = 0;
        end
    endtask

    task automatic cycle(input string ph);
        #1;
        compare(ph);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        disp_valid = 0; disp_pred = 0; disp_s1_ready = 0; disp_s2_ready = 0;
        disp_dest = '0; disp_type = '0; disp_pc = '0; disp_target = '0;
        disp_s1_val = '0; disp_s2_val = '0; disp_s1_tag = '0; disp_s2_tag = '0;
        bc_valid = 0; bc_exc = 0; bc_tag = '0; bc_value = '0;
        wr_valid = 0; wr_exc = 0; wr_idx = '0; wr_value = '0;
        flush_req = 0;
    endtask

    task automatic set_disp(input bit r1, input int v1, input int t1,
                            input bit r2, input int v2, input int t2);
        disp_valid    = 1;
        disp_dest     = REG_W'($urandom);
        disp_type     = TYPE_W'($urandom);
        disp_pc       = ADDR_W'($urandom);
        disp_target   = ADDR_W'($urandom);
        disp_pred     = 1'($urandom);
        disp_s1_ready = r1; disp_s1_val = DATA_W'(v1); disp_s1_tag = IDX_W'(t1);
        disp_s2_ready = r2; disp_s2_val = DATA_W'(v2); disp_s2_tag = IDX_W'(t2);
    endtask

    task automatic set_bc(input int tag, input int val, input bit e);
        bc_valid = 1; bc_tag = IDX_W'(tag); bc_value = DATA_W'(val); bc_exc = e;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog R4: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle();
        rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: empty after reset, every read index idle
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx = IDX_W'(i);
            cycle("R1 reset");
        end

        // R7: dispatch into slot 0 while tag 3 is broadcast; s1 waits on 3, s2 on 6
        set_disp(0, 0, 3, 0, 0, 6);
        set_bc(3, 16'h0abc, 0);
        rd_idx = '0;
        cycle("R7 wake at dispatch");
        idle();
        cycle("R7 wake at dispatch");
        // R6: broadcast to tag 6 (slot 6 free: R5 no result stored)
        set_bc(6, 16'h1234, 0);
        cycle("R6 wake stored");
        idle(); rd_idx = 3'd6;
        cycle("R5 free slot untouched");
        rd_idx = '0;
        cycle("R6 wake stored");

        // R9: direct write to slot 1, then write and broadcast colliding on slot 2
        set_disp(1, 7, 0, 1, 8, 0);
        cycle("R9 setup");
        idle(); wr_valid = 1; wr_idx = 3'd1; wr_value = 16'd55; rd_idx = 3'd1;
        cycle("R9 direct write");
        idle(); set_disp(0, 0, 1, 1, 9, 0);
        cycle("R9 setup");
        idle(); wr_valid = 1; wr_idx = 3'd2; wr_value = 16'd1; wr_exc = 1;
        set_bc(2, 16'd2, 0); rd_idx = 3'd2;
        cycle("R9 collision");
        idle();
        cycle("R9 collision");

        // R3: fill to full while head is not done, then keep requesting
        for (int k = 0; k < DEPTH + 3; k++) begin
            idle(); set_disp(0, 0, k % DEPTH, 1, k, 0);
            rd_idx = IDX_W'(k);
            cycle("R3 fill");
        end

        // R11: flush with dispatch and broadcast in the same cycle
        idle(); flush_req = 1; set_disp(1, 1, 0, 1, 1, 0); set_bc(1, 5, 0);
        cycle("R11 flush");
        idle(); rd_idx = '0;
        cycle("R11 flush");

        // R12: retire, dispatch and broadcast together
        for (int k = 0; k < 4; k++) begin
            idle(); set_disp(1, k, 0, 0, 0, k);
            cycle("R12 setup");
        end
        for (int k = 0; k < 6; k++) begin
            idle(); set_disp(0, 0, k % DEPTH, 1, k, 0);
            set_bc(k % DEPTH, 100 + k, 0);
            wr_valid = 1; wr_idx = IDX_W'((k + 1) % DEPTH); wr_value = DATA_W'(200 + k);
            rd_idx = IDX_W'((k + 2) % DEPTH);
            cycle("R12 concurrent");
        end

        // R10: exception result at head, dispatch during the retiring cycle
        idle(); flush_req = 1;
        cycle("R10 setup");
        for (int k = 0; k < 3; k++) begin
            idle(); set_disp(1, k, 0, 1, k, 0);
            cycle("R10 setup");
        end
        idle(); set_bc(0, 16'hdead, 1);
        cycle("R10 exception");
        idle(); set_disp(1, 3, 0, 1, 3, 0);
        cycle("R10 exception");
        idle();
        cycle("R10 exception");

        // Mixed traffic covering every requirement
        for (int n = 0; n < 4000; n++) begin
            idle();
            if ($urandom_range(0, 9) < 6)
                set_disp(1'($urandom), int'($urandom_range(0, 65535)), int'($urandom_range(0, 7)),
                         1'($urandom), int'($urandom_range(0, 65535)), int'($urandom_range(0, 7)));
            if ($urandom_range(0, 1) == 1)
                set_bc(int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)),
                       $urandom_range(0, 15) == 0);
            if ($urandom_range(0, 4) == 0) begin
                wr_valid = 1; wr_idx = IDX_W'($urandom);
                wr_value = DATA_W'($urandom); wr_exc = $urandom_range(0, 15) == 0;
            end
            flush_req = $urandom_range(0, 63) == 0;
            rd_idx = IDX_W'($urandom);
            cycle("R12 mixed");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule